// File: doc/BRIEF.md
# Tunable Quadrature Downconverter with CIC Decimation

The block takes a stream of real 16-bit signed samples at the converter rate (320 kHz nominal), one per asserted valid cycle. It multiplies each sample by the cosine and the sine of a numerically controlled oscillator, which gives an in-phase and a quadrature product. The oscillator is a 24-bit phase accumulator. Its step comes from a tuning word, so any carrier from 30 kHz to 100 kHz can be moved down to baseband. The tuning word is step = f_carrier / f_sample * 2^24. For example, 30 kHz is 1572864 and 100 kHz is 5242880.

Each product stream passes through a three-stage cascaded integrator-comb decimator with differential delay 1 and rate change 20. One complex baseband sample comes out, with a one-cycle strobe, for every 20 accepted input samples, which is 16 kHz at the nominal rate. The outputs are kept at full width: the 32-bit product plus 15 bits of growth, 47 bits in all. A downstream channel filter picks the bits it needs.

Top module: `ddc_front`

## Requirements
- R1: While rst_ni is low, i_o and q_o are 0 and out_vld_o is 0.
- R2: The 24-bit phase starts at 0 after reset. On each cycle with vld_i high it advances by tune_i, modulo 2^24. Sample n is mixed with the sum of the tuning words presented with samples 0..n-1. A new tuning word therefore acts from the next accepted sample, and the phase is never cleared.
- R3: The oscillator index p is phase[23:14], a 10-bit value. With a = p[7:0], the magnitude is M = round(32767 * sin(pi/2 * k/256)), where k = 256 - a when p[8] = 1 and k = a otherwise. The sine value is M, negated when p[9] = 1. The cosine value is the sine value at index p + 256 (mod 1024).
- R4: The in-phase product is sample * cosine and the quadrature product is sample * sine. Both are full 32-bit signed products.
- R5: Each branch runs three integrators on every accepted product, with all three updated in the same cycle and the sums chained. Every 20th sample, three first-difference combs produce the output. All arithmetic is two's complement on 47 bits and wraps.
- R6: Decimation blocks are runs of 20 accepted samples, counted from reset. Cycles with vld_i low change neither the phase nor any filter state, whatever sample_i and tune_i hold.
- R7: The results of the first three blocks are dropped. The first strobe follows the 80th accepted sample, and each later block gives exactly one strobe.
- R8: out_vld_o is high for single cycles only. i_o and q_o change only in a strobe cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input sample valid |
| sample_i | input | 16 | Real input sample, signed |
| tune_i | input | 24 | Oscillator phase step, sampled with vld_i |
| i_o | output | 47 | In-phase baseband output |
| q_o | output | 47 | Quadrature baseband output |
| out_vld_o | output | 1 | One-cycle strobe marking a new complex output |

## Verification
Four input patterns are used:
- **Constant DC input with a zero tuning word.** The cosine is full scale and the sine is zero, so the known peak value and the CIC gain of 8000 are checked.
- **Random samples at a quarter-cycle step, with random idle gaps.** The table's quadrant endpoints are tested, and the gaps must change nothing.
- **Random samples with the tuning word switched from 30 kHz to 100 kHz in the middle of a block.** This shows whether the phase carries on without a reset and whether the new step takes effect one sample later.
- **Full-scale alternating extremes at an odd step.** This exercises the largest products and the mirrored table addresses.

Dropping the first three blocks is checked by counting the strobes.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned LO_W     = 16;
  localparam int unsigned PHASE_W  = 24;
  localparam int unsigned LUT_AW   = 10;
  localparam int unsigned DECIM    = 20;
  localparam int unsigned STAGES   = 3;

  function automatic int unsigned acc_width(int unsigned in_w, int unsigned lo_w,
                                            int unsigned stages, int unsigned decim);
    return in_w + lo_w + stages * $clog2(decim);
  endfunction
endpackage

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned LUT_AW  = 10,
  parameter int unsigned LO_W    = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic [PHASE_W-1:0]        tune_i,
  output logic [PHASE_W-1:0]        phase_o,
  output logic signed [LO_W-1:0]    sin_o,
  output logic signed [LO_W-1:0]    cos_o
);
  localparam int  QN          = 2 ** (LUT_AW - 2);
  localparam real AMP         = real'(2 ** (LO_W - 1) - 1);
  localparam real QUARTER_RAD = 1.5707963267948966;

  logic [PHASE_W-1:0]     phase_q;
  logic signed [LO_W-1:0] qtab [QN+1];
  logic [LUT_AW-1:0]      addr [2];
  logic signed [LO_W-1:0] lo   [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (vld_i) phase_q <= phase_q + tune_i;
  end

  // quarter-wave table, computed at elaboration, one extra entry for the peak
  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam int VAL = $rtoi(AMP * $sin(QUARTER_RAD * real'(k) / real'(QN)) + 0.5);
    assign qtab[k] = LO_W'(VAL);
  end

  assign addr[0] = phase_q[PHASE_W-1 -: LUT_AW];
  assign addr[1] = addr[0] + LUT_AW'(QN);

  for (genvar c = 0; c < 2; c++) begin : g_lu
    logic [LUT_AW-3:0]      fine;
    logic [LUT_AW-2:0]      idx;
    logic signed [LO_W-1:0] mag;
    assign fine  = addr[c][LUT_AW-3:0];
    assign idx   = addr[c][LUT_AW-2] ? (LUT_AW-1)'(QN) - {1'b0, fine} : {1'b0, fine};
    assign mag   = qtab[idx];
    assign lo[c] = addr[c][LUT_AW-1] ? -mag : mag;
  end

  assign phase_o = phase_q;
  assign sin_o   = lo[0];
  assign cos_o   = lo[1];
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned LO_W     = 16,
  localparam int unsigned PROD_W  = SAMPLE_W + LO_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vld_i,
  input  logic signed [SAMPLE_W-1:0]  sample_i,
  input  logic signed [LO_W-1:0]      sin_i,
  input  logic signed [LO_W-1:0]      cos_i,
  output logic                        vld_o,
  output logic signed [PROD_W-1:0]    i_o,
  output logic signed [PROD_W-1:0]    q_o
);
  logic                       vld_a;
  logic signed [SAMPLE_W-1:0] smp_a;
  logic signed [LO_W-1:0]     sin_a, cos_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_a <= 1'b0;
      smp_a <= '0;
      sin_a <= '0;
      cos_a <= '0;
      vld_o <= 1'b0;
      i_o   <= '0;
      q_o   <= '0;
    end else begin
      vld_a <= vld_i;
      vld_o <= vld_a;
      if (vld_i) begin
        smp_a <= sample_i;
        sin_a <= sin_i;
        cos_a <= cos_i;
      end
      if (vld_a) begin
        i_o <= PROD_W'(smp_a) * PROD_W'(cos_a);
        q_o <= PROD_W'(smp_a) * PROD_W'(sin_a);
      end
    end
  end
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
  parameter int unsigned IN_W   = 32,
  parameter int unsigned ACC_W  = 47,
  parameter int unsigned DECIM  = 20,
  parameter int unsigned STAGES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [IN_W-1:0]  x_i,
  output logic                    vld_o,
  output logic [ACC_W-1:0]        y_o
);
  localparam int unsigned CNT_W  = $clog2(DECIM);
  localparam int unsigned FILL_W = $clog2(STAGES + 1);

  logic [ACC_W-1:0]  ext;
  logic [ACC_W-1:0]  integ_q [STAGES];
  logic [ACC_W-1:0]  integ_n [STAGES];
  logic [ACC_W-1:0]  dly_q   [STAGES];
  logic [ACC_W-1:0]  comb_n  [STAGES];
  logic [CNT_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;
  logic              last;
  logic              blk_vld_q;
  logic [ACC_W-1:0]  blk_q;

  assign ext  = {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};
  assign last = vld_i && (cnt_q == CNT_W'(DECIM - 1));

  // all integrators advance in one cycle so block boundaries align exactly
  always_comb begin
    integ_n[0] = integ_q[0] + ext;
    for (int s = 1; s < STAGES; s++) integ_n[s] = integ_q[s] + integ_n[s-1];
    comb_n[0] = blk_q - dly_q[0];
    for (int s = 1; s < STAGES; s++) comb_n[s] = comb_n[s-1] - dly_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end
      cnt_q     <= '0;
      fill_q    <= '0;
      blk_vld_q <= 1'b0;
      blk_q     <= '0;
      vld_o     <= 1'b0;
      y_o       <= '0;
    end else begin
      blk_vld_q <= last;
      vld_o     <= 1'b0;
      if (vld_i) begin
        for (int s = 0; s < STAGES; s++) integ_q[s] <= integ_n[s];
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      if (last) blk_q <= integ_n[STAGES-1];
      if (blk_vld_q) begin
        dly_q[0] <= blk_q;
        for (int s = 1; s < STAGES; s++) dly_q[s] <= comb_n[s-1];
        if (fill_q == FILL_W'(STAGES)) begin
          vld_o <= 1'b1;
          y_o   <= comb_n[STAGES-1];
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ddc_front.sv
module ddc_front #(
  parameter int unsigned SAMPLE_W = ddc_pkg::SAMPLE_W,
  parameter int unsigned LO_W     = ddc_pkg::LO_W,
  parameter int unsigned PHASE_W  = ddc_pkg::PHASE_W,
  parameter int unsigned LUT_AW   = ddc_pkg::LUT_AW,
  parameter int unsigned DECIM    = ddc_pkg::DECIM,
  parameter int unsigned STAGES   = ddc_pkg::STAGES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [PHASE_W-1:0]         tune_i,
  output logic [ddc_pkg::acc_width(SAMPLE_W, LO_W, STAGES, DECIM)-1:0] i_o,
  output logic [ddc_pkg::acc_width(SAMPLE_W, LO_W, STAGES, DECIM)-1:0] q_o,
  output logic                       out_vld_o
);
  localparam int unsigned PROD_W = SAMPLE_W + LO_W;
  localparam int unsigned ACC_W  = ddc_pkg::acc_width(SAMPLE_W, LO_W, STAGES, DECIM);

  logic [PHASE_W-1:0]       phase_w;
  logic signed [LO_W-1:0]   lo_sin, lo_cos;
  logic                     mix_vld;
  logic signed [PROD_W-1:0] prod [2];
  logic [ACC_W-1:0]         acc  [2];
  logic [1:0]               br_vld;

  ddc_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LO_W(LO_W)) u_nco (
    .clk_i, .rst_ni, .vld_i, .tune_i,
    .phase_o(phase_w), .sin_o(lo_sin), .cos_o(lo_cos)
  );

  ddc_mixer #(.SAMPLE_W(SAMPLE_W), .LO_W(LO_W)) u_mix (
    .clk_i, .rst_ni, .vld_i, .sample_i,
    .sin_i(lo_sin), .cos_i(lo_cos),
    .vld_o(mix_vld), .i_o(prod[0]), .q_o(prod[1])
  );

  for (genvar b = 0; b < 2; b++) begin : g_branch
    ddc_cic #(.IN_W(PROD_W), .ACC_W(ACC_W), .DECIM(DECIM), .STAGES(STAGES)) u_cic (
      .clk_i, .rst_ni, .vld_i(mix_vld), .x_i(prod[b]),
      .vld_o(br_vld[b]), .y_o(acc[b])
    );
  end

  assign i_o       = acc[0];
  assign q_o       = acc[1];
  assign out_vld_o = &br_vld;
endmodule

// File: rtl/ddc_front_chk.sv
module ddc_front_chk #(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned ACC_W   = 47,
  parameter int unsigned DECIM   = 20,
  parameter int unsigned STAGES  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               vld_i,
  input logic [PHASE_W-1:0] tune_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic               out_vld_i,
  input logic [ACC_W-1:0]   i_i,
  input logic [ACC_W-1:0]   q_i
);
  localparam int unsigned FILL_N = DECIM * (STAGES + 1);
  localparam int unsigned FCW    = $clog2(FILL_N + 1);

  logic [FCW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    seen_q <= '0;
    else if (vld_i && seen_q != FCW'(FILL_N))       seen_q <= seen_q + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_vld_i && i_i == '0 && q_i == '0));

  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(vld_i)) |-> phase_i == $past(phase_i) + $past(tune_i));

  a_r6_phase_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(vld_i)) |-> $stable(phase_i));

  a_r7_fill_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_i |-> seen_q == FCW'(FILL_N));

  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_i |=> !out_vld_i);

  a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !out_vld_i) |-> ($stable(i_i) && $stable(q_i)));
endmodule

bind ddc_front ddc_front_chk #(
  .PHASE_W(PHASE_W), .ACC_W(ACC_W), .DECIM(DECIM), .STAGES(STAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .tune_i(tune_i),
  .phase_i(phase_w), .out_vld_i(out_vld_o), .i_i(i_o), .q_i(q_o)
);

// File: tb/ddc_front_bench.sv
module ddc_front_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  ACC_W      = 47;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               vld = 1'b0;
  logic signed [15:0] smp = '0;
  logic [23:0]        tune = '0;
  logic [ACC_W-1:0]   i_o, q_o;
  logic               out_vld;

  int checks = 0;
  int fails  = 0;
  int n_out  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_front u_ddc_front (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .sample_i(smp), .tune_i(tune),
    .i_o(i_o), .q_o(q_o), .out_vld_o(out_vld)
  );

  // reference model state
  logic [23:0]      m_ph = '0;
  logic [ACC_W-1:0] m_int [2][3];
  logic [ACC_W-1:0] m_dly [2][3];
  int               m_cnt = 0;
  int               m_blk = 0;
  logic [2*ACC_W-1:0] expq [$];

  function automatic logic signed [15:0] lo_ref(input logic [9:0] p);
    int a, k, m;
    a = int'(p[7:0]);
    k = p[8] ? 256 - a : a;
    m = $rtoi(32767.0 * $sin(1.5707963267948966 * real'(k) / 256.0) + 0.5);
    return p[9] ? 16'(-m) : 16'(m);
  endfunction

  task automatic check(input bit ok, input string what, input logic [ACC_W-1:0] act,
                       input logic [ACC_W-1:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp_v);
    end
  endtask

  // driver: applies one sample and advances the model (R2 R3 R4 R5)
  task automatic send(input logic signed [15:0] x, input logic [23:0] tw, input int gap);
    logic signed [15:0] lo [2];
    logic signed [31:0] pr;
    logic [ACC_W-1:0]   v, c0, c1, c2;
    logic [ACC_W-1:0]   res [2];
    @(negedge clk);
    vld = 1'b1; smp = x; tune = tw;
    lo[0] = lo_ref(m_ph[23:14] + 10'd256);
    lo[1] = lo_ref(m_ph[23:14]);
    m_ph = m_ph + tw;
    for (int b = 0; b < 2; b++) begin
      pr = x * lo[b];
      m_int[b][0] = m_int[b][0] + ACC_W'(pr);
      m_int[b][1] = m_int[b][1] + m_int[b][0];
      m_int[b][2] = m_int[b][2] + m_int[b][1];
    end
    m_cnt++;
    if (m_cnt == 20) begin
      m_cnt = 0;
      for (int b = 0; b < 2; b++) begin
        v  = m_int[b][2];
        c0 = v - m_dly[b][0];  m_dly[b][0] = v;
        c1 = c0 - m_dly[b][1]; m_dly[b][1] = c0;
        c2 = c1 - m_dly[b][2]; m_dly[b][2] = c1;
        res[b] = c2;
      end
      if (m_blk >= 3) expq.push_back({res[0], res[1]});  // R7
      m_blk++;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      vld = 1'b0; smp = 16'($urandom); tune = 24'($urandom);  // R6 idle garbage
    end
  endtask

  // monitor / scoreboard
  logic [ACC_W-1:0] last_i = '0, last_q = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        n_out++;
        if (expq.size() == 0) begin
          check(1'b0, "R7 strobe with no expected block", i_o, '0);
        end else begin
          logic [2*ACC_W-1:0] e;
          e = expq.pop_front();
          check(i_o == e[2*ACC_W-1:ACC_W], "R3 R4 R5 R6 in-phase", i_o, e[2*ACC_W-1:ACC_W]);
          check(q_o == e[ACC_W-1:0], "R3 R4 R5 R6 quadrature", q_o, e[ACC_W-1:0]);
        end
        last_i = i_o; last_q = q_o;
      end else if (i_o != last_i || q_o != last_q) begin
        check(1'b0, "R8 output moved without strobe", i_o, last_i);
      end
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 3; s++) begin m_int[b][s] = '0; m_dly[b][s] = '0; end
    repeat (3) @(negedge clk);
    check(i_o == '0, "R1 reset i_o", i_o, '0);
    check(q_o == '0, "R1 reset q_o", q_o, '0);
    check(out_vld == 1'b0, "R1 reset strobe", ACC_W'(out_vld), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // DC input, zero step: cosine at full scale, sine zero
    for (int n = 0; n < 100; n++) send(16'sd1000, 24'd0, 0);
    // quarter-cycle step, random data, idle gaps
    for (int n = 0; n < 200; n++) send(16'($urandom), 24'h400000, int'($urandom_range(0, 3)));
    // 30 kHz then 100 kHz, switched inside a block (R2)
    for (int n = 0; n < 110; n++) send(16'($urandom), 24'd1572864, int'($urandom_range(0, 1)));
    for (int n = 0; n < 90; n++)  send(16'($urandom), 24'd5242880, 0);
    // full-scale extremes at an odd step
    for (int n = 0; n < 100; n++) send((n % 2) ? 16'sh7fff : 16'sh8000, 24'd3000001, 0);

    @(negedge clk); vld = 1'b0;
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R7 blocks left unreported", ACC_W'(expq.size()), '0);
    check(n_out == 27, "R7 strobe count", ACC_W'(n_out), ACC_W'(27));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired, R6 R7 stall actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule